// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface

This block models the command front end of a byte-wide parallel flash device, running in a single clock domain. It samples active-low chip, output and write enables together with a 16-bit address and an 8-bit input data bus. Keyed unlock write sequences are decoded into byte program, chip erase, boot-region lockout and identification-mode entry and exit. Program and erase run as busy periods of a fixed number of clock cycles, set by parameters. While an operation is busy, reads return status bits in place of array contents.

The storage is a small window of cells. A cell index is formed from one boot-region flag (set when the address is below 0x2000) and the low `WIN_AW` address bits. Addresses that share both of these alias to the same cell. After reset every cell holds 0xFF. The bus has no back-pressure: a write is accepted or dropped once it completes, and a read result follows the enables after a fixed latency.

Top module: `flash_cmd_if`

## Requirements
- R1: `dout_en` is 1 exactly two clock edges after the sampled pins show chip enable low, output enable low and write enable high. Otherwise `dout_en` is 0 and `dout` is 0x00, which is also the state after reset.
- R2: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 and then target/data program the target cell. When the busy period ends, the cell holds the old value ANDed with the data.
- R3: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10 start a chip erase. When it ends, every cell that is not protected reads 0xFF.
- R4: The same six-write pattern with final data 0x40 sets a lock flag that only reset clears. While the flag is set, cells in the boot region (address below 0x2000) are neither programmed nor erased.
- R5: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 enter identification mode. In this mode address 0x0000 reads 0x1F, address 0x0001 reads 0x03, address 0x0002 reads the lock flag on bit 0, and other addresses read 0x00. A write of 0xF0 leaves the mode, either as a single write to any address or at the end of the three-write prefix.
- R6: While a program is busy, every read returns the complement of bit 7 of the programmed data on bit 7. During an erase, bit 7 reads 0. Bits 5:0 read 0.
- R7: While busy, bit 6 starts at 0 when the operation begins and inverts on each new read access (a rising edge of the read enable). The first read therefore shows 1.
- R8: A write that does not match the next expected step returns the decoder to idle. The following writes must then restart from the first step.
- R9: Writes that complete while an operation is busy are ignored.
- R10: A write completes when chip enable or write enable rises after both were low. The address is taken when both first become low, and the data from the last sampled cycle before the rise. If output enable is low, no write cycle occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | High when `dout` is driven onto the bus |

## Verification
The hardest conditions to reach are those inside a busy window. Bench overrides lengthen the program and erase periods so that several complete read accesses, or a whole second program sequence, fit inside one operation. This lets the toggle sequence and the dropped writes be observed. Lockout protection is only visible after a boot cell has been written before the lock and a chip erase has run after it, so the stimulus orders these steps on purpose. The sequence runs program, then lock, then erase, and reads the boot cell back at the end.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_KEY1, S_KEY2, S_PGM, S_ER1, S_ER2, S_ER3
  } seq_state_t;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [15:0] BOOT_LIMIT = 16'h2000;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  OP_PROGRAM = 8'hA0;
  localparam logic [7:0]  OP_ER_PRE  = 8'h80;
  localparam logic [7:0]  OP_ERASE   = 8'h10;
  localparam logic [7:0]  OP_LOCK    = 8'h40;
  localparam logic [7:0]  OP_ID_IN   = 8'h90;
  localparam logic [7:0]  OP_ID_OUT  = 8'hF0;
  localparam logic [7:0]  MFR_CODE   = 8'h1F;
  localparam logic [7:0]  DEV_CODE   = 8'h03;

  function automatic logic in_boot(input logic [15:0] a);
    return a < BOOT_LIMIT;
  endfunction
endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [15:0] addr,
  input  logic [7:0]  din,
  output logic        ce_s,
  output logic        oe_s,
  output logic        we_s,
  output logic [15:0] addr_s,
  output logic        wr_stb,
  output logic [15:0] wr_addr,
  output logic [7:0]  wr_data
);
  logic       act, act_q;
  logic [7:0] din_s;

  // one sampling stage for all bus pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_s   <= 1'b1;
      oe_s   <= 1'b1;
      we_s   <= 1'b1;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      ce_s   <= ce_n;
      oe_s   <= oe_n;
      we_s   <= we_n;
      addr_s <= addr;
      din_s  <= din;
    end
  end

  // a write pulse is live while both enables are low and output enable is high
  assign act = ~ce_s & ~we_s & oe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) wr_addr <= addr_s;
      if (act) wr_data <= din_s;
    end
  end

  // commit only when the pulse ended by an enable rising, not by output enable
  assign wr_stb = act_q & ~act & (ce_s | we_s);
endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        busy,
  output logic        pgm_go,
  output logic        erase_go,
  output logic [15:0] tgt_addr,
  output logic [7:0]  tgt_data,
  output logic        locked,
  output logic        id_mode
);
  seq_state_t state;
  logic       accept, at_a, at_b;

  assign accept = wr_stb & ~busy;
  assign at_a   = (wr_addr == KEY_ADDR_A);
  assign at_b   = (wr_addr == KEY_ADDR_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pgm_go   <= 1'b0;
      erase_go <= 1'b0;
      tgt_addr <= '0;
      tgt_data <= '0;
      locked   <= 1'b0;
      id_mode  <= 1'b0;
    end else begin
      pgm_go   <= 1'b0;
      erase_go <= 1'b0;
      if (accept) begin
        state <= S_IDLE;
        if (state != S_PGM && wr_data == OP_ID_OUT) begin
          id_mode <= 1'b0;
        end else begin
          case (state)
            S_IDLE: if (at_a && wr_data == KEY_DATA_A) state <= S_KEY1;
            S_KEY1: if (at_b && wr_data == KEY_DATA_B) state <= S_KEY2;
            S_KEY2: begin
              if (at_a) begin
                case (wr_data)
                  OP_PROGRAM: state <= S_PGM;
                  OP_ER_PRE:  state <= S_ER1;
                  OP_ID_IN:   id_mode <= 1'b1;
                  default:    state <= S_IDLE;
                endcase
              end
            end
            S_PGM: begin
              if (!(locked && in_boot(wr_addr))) begin
                pgm_go   <= 1'b1;
                tgt_addr <= wr_addr;
                tgt_data <= wr_data;
              end
            end
            S_ER1: if (at_a && wr_data == KEY_DATA_A) state <= S_ER2;
            S_ER2: if (at_b && wr_data == KEY_DATA_B) state <= S_ER3;
            S_ER3: begin
              if (at_a && wr_data == OP_ERASE) erase_go <= 1'b1;
              if (at_a && wr_data == OP_LOCK)  locked   <= 1'b1;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_go,
  input  logic erase_go,
  output logic busy,
  output logic is_erase,
  output logic done
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_erase <= 1'b0;
      cnt      <= '0;
    end else if (pgm_go || erase_go) begin
      busy     <= 1'b1;
      is_erase <= erase_go;
      cnt      <= erase_go ? ERASE_LAST : PROG_LAST;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy & (cnt == '0);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_cmd_pkg::*;
#(
  parameter int WIN_AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  input  logic        done,
  input  logic        is_erase,
  input  logic        locked,
  input  logic [15:0] tgt_addr,
  input  logic [7:0]  tgt_data
);
  localparam int IW    = WIN_AW + 1;
  localparam int DEPTH = 1 << IW;

  logic [7:0]    cells [DEPTH];
  logic [IW-1:0] rd_idx, tgt_idx;

  assign rd_idx  = {in_boot(rd_addr),  rd_addr[WIN_AW-1:0]};
  assign tgt_idx = {in_boot(tgt_addr), tgt_addr[WIN_AW-1:0]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [IW-1:0] MY_IDX = IW'(g);
    localparam bit            IS_BOOT = MY_IDX[IW-1];
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= 8'hFF;
      end else if (done) begin
        if (is_erase) begin
          if (!(IS_BOOT && locked)) cell_q <= 8'hFF;
        end else if (tgt_idx == MY_IDX) begin
          cell_q <= cell_q & tgt_data;
        end
      end
    end
    assign cells[g] = cell_q;
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int WIN_AW       = 5,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [15:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en
);
  logic        ce_s, oe_s, we_s;
  logic [15:0] addr_s, wr_addr, tgt_addr;
  logic [7:0]  wr_data, tgt_data, arr_rd, rd_val;
  logic        wr_stb, pgm_go, erase_go, locked, id_mode;
  logic        busy, is_erase, done;
  logic        rd_en, rd_en_q, rd_start, tog, tog_nx;

  flash_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .addr_s(addr_s), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_seq_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .pgm_go(pgm_go), .erase_go(erase_go),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .locked(locked), .id_mode(id_mode)
  );

  flash_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .pgm_go(pgm_go), .erase_go(erase_go),
    .busy(busy), .is_erase(is_erase), .done(done)
  );

  flash_cell_array #(.WIN_AW(WIN_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr_s), .rd_data(arr_rd),
    .done(done), .is_erase(is_erase), .locked(locked),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  assign rd_en    = ~ce_s & ~oe_s & we_s;
  assign rd_start = rd_en & ~rd_en_q;
  assign tog_nx   = (busy && rd_start) ? ~tog : tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      tog     <= 1'b0;
    end else begin
      rd_en_q <= rd_en;
      if (pgm_go || erase_go) tog <= 1'b0;
      else                    tog <= tog_nx;
    end
  end

  always_comb begin
    if (busy) begin
      rd_val = {(is_erase ? 1'b0 : ~tgt_data[7]), tog_nx, 6'b000000};
    end else if (id_mode) begin
      case (addr_s)
        16'h0000: rd_val = MFR_CODE;
        16'h0001: rd_val = DEV_CODE;
        16'h0002: rd_val = {7'b0000000, locked};
        default:  rd_val = 8'h00;
      endcase
    end else begin
      rd_val = arr_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 8'h00;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_en;
      dout    <= rd_en ? rd_val : 8'h00;
    end
  end
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       oe_s,
  input logic       busy,
  input logic       locked,
  input logic       id_mode,
  input logic       pgm_go,
  input logic       erase_go,
  input logic       rd_start,
  input logic       tog,
  input logic [7:0] dout,
  input logic       dout_en
);
  // R10
  oe_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> oe_s);

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> ($stable(locked) && $stable(id_mode) && !pgm_go && !erase_go));

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(locked));

  // R7
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (tog != $past(tog)));

  // R6
  status_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && dout_en) |-> (dout[5:0] == 6'b000000));

  // R1
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00));
endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .oe_s(oe_s), .busy(busy),
  .locked(locked), .id_mode(id_mode), .pgm_go(pgm_go), .erase_go(erase_go),
  .rd_start(rd_start), .tog(tog), .dout(dout), .dout_en(dout_en)
);

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  flash_cmd_if #(.WIN_AW(5), .PROG_CYCLES(60), .ERASE_CYCLES(80)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // monitor: pops expected read results and compares at the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      n_tests++;
      if (dout !== e.exp || dout_en !== 1'b1) begin
        n_fail++;
        $display("FAIL %s: dout=%h en=%b expected %h en=1", e.tag, dout, dout_en, e.exp);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_bus(input logic [15:0] a, input logic [7:0] d, input logic oe_lvl);
    @(negedge clk);
    addr = a; din = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_bus(a, d, 1'b1);
  endtask

  task automatic prefix(input logic [7:0] op);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, op);
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    prefix(8'hA0); wr(a, d);
  endtask

  task automatic six(input logic [7:0] last);
    prefix(8'h80); prefix(last);
  endtask

  // driver: performs one read access and queues the expected byte
  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) @(negedge clk);
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    repeat (2) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dout_en === 1'b0 && dout === 8'h00, "R1 reset", dout, 8'h00);
    rd(16'h3000, 8'hFF, "R2 erased after reset");

    // R2 program, R6/R7 status during busy
    prog(16'h3000, 8'h5A);
    rd(16'h3000, 8'hC0, "R6 R7 first busy read");
    rd(16'h3000, 8'h80, "R7 second busy read");
    repeat (80) @(negedge clk);
    rd(16'h3000, 8'h5A, "R2 programmed value");
    prog(16'h3000, 8'h0F);
    repeat (80) @(negedge clk);
    rd(16'h3000, 8'h0A, "R2 AND with old value");

    // R8 broken sequence
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h56); wr(16'h5555, 8'hA0); wr(16'h3001, 8'h00);
    repeat (80) @(negedge clk);
    rd(16'h3001, 8'hFF, "R8 broken sequence ignored");

    // R5 identification mode
    prefix(8'h90);
    rd(16'h0000, 8'h1F, "R5 maker code");
    rd(16'h0001, 8'h03, "R5 device code");
    rd(16'h0002, 8'h00, "R5 unlocked status");
    wr(16'h1234, 8'hF0);
    rd(16'h3000, 8'h0A, "R5 single write exit");

    // R4 lockout
    prog(16'h0010, 8'h33);
    repeat (80) @(negedge clk);
    rd(16'h0010, 8'h33, "R4 boot cell before lock");
    six(8'h40);
    prefix(8'h90);
    rd(16'h0002, 8'h01, "R4 R5 locked status");
    prefix(8'hF0);
    rd(16'h3000, 8'h0A, "R5 three write exit");
    prog(16'h0011, 8'h00);
    repeat (80) @(negedge clk);
    rd(16'h0011, 8'hFF, "R4 boot program blocked");

    // R9 writes during busy
    prog(16'h3002, 8'h00);
    prog(16'h3003, 8'h00);
    repeat (80) @(negedge clk);
    rd(16'h3002, 8'h00, "R9 first program done");
    rd(16'h3003, 8'hFF, "R9 busy write ignored");

    // R3 erase honouring lock
    six(8'h10);
    rd(16'h3000, 8'h40, "R3 R6 erase status");
    repeat (100) @(negedge clk);
    rd(16'h3000, 8'hFF, "R3 main erased");
    rd(16'h3002, 8'hFF, "R3 main erased second");
    rd(16'h0010, 8'h33, "R4 boot kept by erase");

    // R1 output disabled with output enable high
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dout_en === 1'b0 && dout === 8'h00, "R1 output disabled", dout, 8'h00);
    ce_n = 1'b1;

    // R10 write blocked by output enable low
    prefix(8'hA0);
    wr_bus(16'h3004, 8'h00, 1'b0);
    repeat (80) @(negedge clk);
    rd(16'h3004, 8'hFF, "R10 blocked write");

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule